// File: doc/BRIEF.md
# Program Page Window Address Expander

This block widens a 16-bit logical CPU address into a 20-bit physical program-memory address. A fixed 16 KB region of the logical map, 0x8000 to 0xBFFF, acts as a window. Whichever 16 KB page of physical program memory a 6-bit page register selects appears in that window. Sixty-four pages give up to 1 MB of reachable program memory. Addresses outside the window pass through unchanged, zero-extended to 20 bits. A flag reports whether the current address fell inside the window.

Software reaches the page register over a small synchronous register bus. The bus has separate read and write strobes. The register answers at offset 0x30 above a module base address, and the base is an input that the integrator may relocate.

An integration parameter chooses one of two variants. In the open variant the register resets to 0x00 and accepts writes in every mode. In the guarded variant it resets to 0x3C and accepts writes only while the special-mode input is high.

Address translation is purely combinational, and the register port is a plain strobe interface. No stream data flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `prog_page_mapper`

## Requirements
- R1: When log_addr[15:14] equals 2'b10, phys_addr equals {page[5:0], log_addr[13:0]} and in_window is 1, in the same cycle.
- R2: For every other logical address, phys_addr equals {4'b0000, log_addr} and in_window is 0.
- R3: After reset the page register holds 0x00 in the open variant and 0x3C in the guarded variant.
- R4: The register responds only when bus_addr equals mod_base + 0x0030, computed modulo 2^16. Writes to any other address leave the page unchanged, and reads of any other address return 0x00.
- R5: bus_rdata[7:6] always read as 0, and bits 7:6 of bus_wdata have no effect.
- R6: A read strobe in cycle N returns the register value on bus_rdata in cycle N+1. When cycle N held no read of the register, bus_rdata is 0x00 in cycle N+1.
- R7: A permitted write in cycle N leaves the translation unchanged during cycle N. The new page drives the translation from cycle N+1 onward.
- R8: In the open variant, writes take effect whatever the level of special_mode.
- R9: In the guarded variant, a write while special_mode is 0 is ignored. A write while special_mode is 1 takes effect.
- R10: When a read and a write hit the register in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_base | input | 16 | Relocatable module base address |
| special_mode | input | 1 | High while the chip runs in special mode |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, valid the cycle after the read strobe |
| log_addr | input | 16 | Logical CPU address |
| phys_addr | output | 20 | Physical program-memory address |
| in_window | output | 1 | High when log_addr lies in the page window |

## Verification
The page register can only be observed through the translation and through register reads. A corrupted or wrongly reset page therefore shows up in phys_addr bits 19:14 in the first cycle after the bad update, for any in-window address. The same fault appears on bus_rdata one cycle after a read strobe. A write that lands one cycle early or late shows as a mismatch in the cycle of the write or the cycle after it. A permission or decode fault shows as a page that changed when it should have held. The bench drives both variants side by side with identical stimulus, so a difference in policy or reset value shows up at once.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

  typedef enum logic {
    POLICY_OPEN    = 1'b0,
    POLICY_GUARDED = 1'b1
  } wr_policy_e;

  localparam logic [7:0] RESET_OPEN    = 8'h00;
  localparam logic [7:0] RESET_GUARDED = 8'h3C;

  function automatic logic [7:0] reset_for(input wr_policy_e pol);
    return (pol == POLICY_GUARDED) ? RESET_GUARDED : RESET_OPEN;
  endfunction

endpackage

// File: rtl/ppw_page_reg.sv
module ppw_page_reg #(
  parameter int unsigned PAGE_BITS = 6,
  parameter logic [7:0]  RESET_VAL = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [PAGE_BITS-1:0] load_val,
  output logic [PAGE_BITS-1:0] page
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      page <= RESET_VAL[PAGE_BITS-1:0];
    else if (load)
      page <= load_val;
  end

endmodule

// File: rtl/ppw_bus_port.sv
module ppw_bus_port #(
  parameter int unsigned          ADDR_W     = 16,
  parameter int unsigned          DATA_W     = 8,
  parameter int unsigned          PAGE_BITS  = 6,
  parameter logic [15:0]          REG_OFFSET = 16'h0030,
  parameter ppw_pkg::wr_policy_e  POLICY     = ppw_pkg::POLICY_OPEN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    mod_base,
  input  logic                 special_mode,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [PAGE_BITS-1:0] page,
  output logic                 load,
  output logic [PAGE_BITS-1:0] load_val,
  output logic [DATA_W-1:0]    bus_rdata
);

  localparam int unsigned PAD_W = DATA_W - PAGE_BITS;

  logic [ADDR_W-1:0] reg_addr;
  logic              hit;
  logic              allowed;

  assign reg_addr = mod_base + REG_OFFSET[ADDR_W-1:0];
  assign hit      = (bus_addr == reg_addr);
  assign allowed  = (POLICY == ppw_pkg::POLICY_GUARDED) ? special_mode : 1'b1;
  assign load     = bus_wr && hit && allowed;
  assign load_val = bus_wdata[PAGE_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd && hit)
      bus_rdata <= {{PAD_W{1'b0}}, page};
    else
      bus_rdata <= '0;
  end

endmodule

// File: rtl/ppw_xlate.sv
module ppw_xlate #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 6,
  parameter int unsigned WIN_BITS  = 14,
  parameter logic [15:0] WIN_BASE  = 16'h8000
) (
  input  logic [ADDR_W-1:0]             log_addr,
  input  logic [PAGE_BITS-1:0]          page,
  output logic [PAGE_BITS+WIN_BITS-1:0] phys_addr,
  output logic                          in_window
);

  localparam int unsigned PHYS_W = PAGE_BITS + WIN_BITS;
  localparam int unsigned TAG_W  = ADDR_W - WIN_BITS;
  localparam int unsigned EXT_W  = PHYS_W - ADDR_W;

  assign in_window = (log_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:ADDR_W-TAG_W]);

  always_comb begin
    if (in_window)
      phys_addr = {page, log_addr[WIN_BITS-1:0]};
    else
      phys_addr = {{EXT_W{1'b0}}, log_addr};
  end

endmodule

// File: rtl/prog_page_mapper.sv
module prog_page_mapper #(
  parameter int unsigned         ADDR_W     = 16,
  parameter int unsigned         DATA_W     = 8,
  parameter int unsigned         PAGE_BITS  = 6,
  parameter int unsigned         WIN_BITS   = 14,
  parameter logic [15:0]         WIN_BASE   = 16'h8000,
  parameter logic [15:0]         REG_OFFSET = 16'h0030,
  parameter ppw_pkg::wr_policy_e POLICY     = ppw_pkg::POLICY_OPEN,
  localparam int unsigned        PHYS_W     = PAGE_BITS + WIN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mod_base,
  input  logic              special_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ADDR_W-1:0] log_addr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              in_window
);

  localparam logic [7:0] RESET_VAL = ppw_pkg::reset_for(POLICY);

  logic [PAGE_BITS-1:0] page_q;
  logic                 load;
  logic [PAGE_BITS-1:0] load_val;

  ppw_bus_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
    .REG_OFFSET(REG_OFFSET), .POLICY(POLICY)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .mod_base(mod_base), .special_mode(special_mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .page(page_q), .load(load), .load_val(load_val), .bus_rdata(bus_rdata)
  );

  ppw_page_reg #(
    .PAGE_BITS(PAGE_BITS), .RESET_VAL(RESET_VAL)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .page(page_q)
  );

  ppw_xlate #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
  ) u_xlate (
    .log_addr(log_addr), .page(page_q), .phys_addr(phys_addr), .in_window(in_window)
  );

endmodule

// File: rtl/ppw_checker.sv
module ppw_checker #(
  parameter int unsigned         ADDR_W     = 16,
  parameter int unsigned         DATA_W     = 8,
  parameter int unsigned         PAGE_BITS  = 6,
  parameter int unsigned         WIN_BITS   = 14,
  parameter logic [15:0]         REG_OFFSET = 16'h0030,
  parameter ppw_pkg::wr_policy_e POLICY     = ppw_pkg::POLICY_OPEN
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             mod_base,
  input logic                          special_mode,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_wr,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic [ADDR_W-1:0]             log_addr,
  input logic [PAGE_BITS+WIN_BITS-1:0] phys_addr,
  input logic                          in_window,
  input logic [PAGE_BITS-1:0]          page_q
);

  localparam int unsigned EXT_W = PAGE_BITS + WIN_BITS - ADDR_W;

  logic armed;
  logic at_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign at_reg = (bus_addr == mod_base + REG_OFFSET[ADDR_W-1:0]);

  // R1: the in-window result keeps the offset bits and carries the page on top
  assert_window_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (phys_addr == {page_q, log_addr[WIN_BITS-1:0]}));

  // R2: outside the window the address passes through zero-extended
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> (phys_addr == {{EXT_W{1'b0}}, log_addr}));

  // R5: the unimplemented upper read bits stay zero
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PAGE_BITS] == '0);

  // R4: the page holds unless the register itself is written
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !(bus_wr && at_reg) |=> $stable(page_q));

  // R7: a permitted write shows up one cycle later
  assert_write_delay_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (bus_wr && at_reg && (POLICY == ppw_pkg::POLICY_OPEN || special_mode))
      |=> (page_q == $past(bus_wdata[PAGE_BITS-1:0])));

  // R9: the guarded variant ignores writes outside special mode
  assert_guard_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (POLICY == ppw_pkg::POLICY_GUARDED && !special_mode) |=> $stable(page_q));

endmodule

bind prog_page_mapper ppw_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
  .WIN_BITS(WIN_BITS), .REG_OFFSET(REG_OFFSET), .POLICY(POLICY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_base(mod_base), .special_mode(special_mode),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .log_addr(log_addr), .phys_addr(phys_addr), .in_window(in_window), .page_q(page_q)
);

// File: tb/tb_prog_page_mapper.sv
`timescale 1ns/100ps
module tb_prog_page_mapper;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mod_base = 16'h0000;
  logic        special_mode = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [15:0] log_addr = 16'h8000;

  logic [7:0]  rd_o, rd_g;
  logic [19:0] pa_o, pa_g;
  logic        win_o, win_g;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  prog_page_mapper dut (
    .clk(clk), .rst_n(rst_n), .mod_base(mod_base), .special_mode(special_mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rd_o), .log_addr(log_addr), .phys_addr(pa_o), .in_window(win_o)
  );

  prog_page_mapper #(.POLICY(ppw_pkg::POLICY_GUARDED)) dut_g (
    .clk(clk), .rst_n(rst_n), .mod_base(mod_base), .special_mode(special_mode),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rd_g), .log_addr(log_addr), .phys_addr(pa_g), .in_window(win_g)
  );

  typedef struct {
    int          kind;   // 0 open phys, 1 open win, 2 open rdata, 3..5 guarded same
    logic [19:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  task automatic push(input int k, input logic [19:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic expect_xl(input logic [19:0] po, input logic wo,
                           input logic [19:0] pg, input logic wg, input string t);
    push(0, po, t); push(1, {19'd0, wo}, t);
    push(3, pg, t); push(4, {19'd0, wg}, t);
  endtask

  task automatic expect_rd(input logic [7:0] eo, input logic [7:0] eg, input string t);
    push(2, {12'd0, eo}, t); push(5, {12'd0, eg}, t);
  endtask

  task automatic cyc(input bit w, input bit r, input logic [15:0] a,
                     input logic [7:0] d, input bit sm);
    @(posedge clk); #1;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; special_mode = sm;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, bus_addr, 8'h00, special_mode);
  endtask

  // monitor: drains every expectation queued in the current cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [19:0] got;
      it = sb.pop_front();
      case (it.kind)
        0: got = pa_o;
        1: got = {19'd0, win_o};
        2: got = {12'd0, rd_o};
        3: got = pa_g;
        4: got = {19'd0, win_g};
        default: got = {12'd0, rd_g};
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, got, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    log_addr = 16'h8000;
    // R3: reset page values seen through translation
    expect_xl(20'h00000, 1'b1, 20'hF0000, 1'b1, "R3 reset xlate");
    cyc(1'b0, 1'b1, 16'h0030, 8'h00, 1'b0);
    idle();
    expect_rd(8'h00, 8'h3C, "R3 R6 reset read");
    idle();
    expect_rd(8'h00, 8'h00, "R6 no read gives zero");

    // R7 R8 R9: write outside special mode
    log_addr = 16'h9234;
    cyc(1'b1, 1'b0, 16'h0030, 8'hC5, 1'b0);
    expect_xl(20'h01234, 1'b1, 20'hF1234, 1'b1, "R7 old page during write");
    idle();
    expect_xl(20'h15234, 1'b1, 20'hF1234, 1'b1, "R7 R8 R9 R1 after write");
    cyc(1'b0, 1'b1, 16'h0030, 8'h00, 1'b0);
    idle();
    expect_rd(8'h05, 8'h3C, "R5 R9 read back");

    // R2: addresses outside the window
    log_addr = 16'h4321; #0;
    expect_xl(20'h04321, 1'b0, 20'h04321, 1'b0, "R2 low");
    idle(); log_addr = 16'hC000;
    expect_xl(20'h0C000, 1'b0, 20'h0C000, 1'b0, "R2 above window");
    idle(); log_addr = 16'h7FFF;
    expect_xl(20'h07FFF, 1'b0, 20'h07FFF, 1'b0, "R2 below window");
    idle(); log_addr = 16'hBFFF;
    expect_xl(20'h17FFF, 1'b1, 20'hF3FFF, 1'b1, "R1 window top");

    // R4: relocated base
    mod_base = 16'h0800;
    cyc(1'b1, 1'b0, 16'h0030, 8'h11, 1'b1);
    cyc(1'b0, 1'b1, 16'h0830, 8'h00, 1'b1);
    idle();
    expect_rd(8'h05, 8'h3C, "R4 stale address write ignored");
    cyc(1'b0, 1'b1, 16'h0030, 8'h00, 1'b1);
    idle();
    expect_rd(8'h00, 8'h00, "R4 stale address read zero");

    // R9: guarded write in special mode
    cyc(1'b1, 1'b0, 16'h0830, 8'h2A, 1'b1);
    idle();
    log_addr = 16'hA000;
    expect_xl(20'hAA000, 1'b1, 20'hAA000, 1'b1, "R9 R8 special write");

    // R10: read and write together
    cyc(1'b1, 1'b1, 16'h0830, 8'h3F, 1'b1);
    idle();
    expect_rd(8'h2A, 8'h2A, "R10 read returns old");
    cyc(1'b0, 1'b1, 16'h0830, 8'h00, 1'b0);
    idle();
    expect_rd(8'h3F, 8'h3F, "R10 R6 new value");
    log_addr = 16'hBFFF;
    expect_xl(20'hFFFFF, 1'b1, 20'hFFFFF, 1'b1, "R1 top page");

    idle();
    idle();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule